// File: doc/BRIEF.md
# Coherency Port Snoop Enable Controller

This block decides, for each slave port of a coherent interconnect, whether that port takes part in snoop traffic and whether it receives distributed-virtual-memory (DVM) maintenance messages. Software sets a port's two enables through a small control register for that port. The new setting does not take effect at once. The block first raises a request to that port's snoop logic, carrying the new pair of enables. The applied enable levels change only when the port acknowledges the request.

A single global "change pending" status bit reads 1 while any port has a change in flight or waiting. Software writes a port's control register and then polls the status bit until it reads 0. No interrupt is involved.

A port that is already in a handshake can take one more change. That change is held in a one-entry slot per port, and the latest write to the slot wins. It is launched as soon as the current handshake completes. The default build serves five ports: two fully coherent ports and three I/O-coherent lite ports. All five behave the same here.

Top module: `snoop_port_ctrl`

## Requirements
- R1: After reset, every snoop enable, message enable and request line is 0, and the change-pending status is 0.
- R2: The register map is as follows. The control register of port k (0-based) is at byte address (k+1)*0x1000, offset 0. In it, bit 0 is the snoop enable and bit 1 is the message enable. The status register is at address 0x000C, and bit 0 is the change-pending flag. A read returns data with a valid pulse one cycle after the read strobe. A port read returns the applied enables. Any other address reads 0.
- R3: A write to an idle port whose value differs from the applied enables raises that port's request from the next cycle. The request carries the written bits, and change-pending goes to 1. The applied enables stay unchanged.
- R4: While a request is raised and not acknowledged, it stays raised and its carried value does not change.
- R5: An acknowledge on a raised request makes the applied enables equal to the carried value from the next cycle. With nothing waiting, the request drops in that same cycle.
- R6: A write to an idle port with a value equal to its applied enables raises no request and leaves change-pending at 0.
- R7: Change-pending stays 1 while any port has a change in flight or waiting. It clears the cycle after the last acknowledge.
- R8: A write to a port with a raised request is held in that port's one-entry slot, and a later write replaces it. On the acknowledge, the held value is sent from the next cycle with the request kept raised.
- R9: A write made during a handshake whose value equals the value in flight empties that port's slot.
- R10: Writes to unmapped addresses and to the status register change nothing. An acknowledge on a port without a raised request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 16 | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| portAck | input | NUM_PORTS | Per-port handshake acknowledge |
| portReqValid | output | NUM_PORTS | Per-port change request |
| portReqSnoop | output | NUM_PORTS | Snoop enable value carried by the request |
| portReqMsg | output | NUM_PORTS | Message enable value carried by the request |
| snoopEn | output | NUM_PORTS | Applied snoop enables |
| msgEn | output | NUM_PORTS | Applied message enables |
| changePending | output | 1 | Any change in flight or waiting |

## Verification
A write is registered on one edge. Its request and the change-pending flag are therefore due one cycle after the write strobe, and the applied enables move one cycle after the acknowledge. The bench drives strobes for exactly one cycle and samples levels on the falling edge right after the edge that must produce them. Reads go through a scoreboard: the driver queues the expected word, and a monitor pops it on the falling edge where busRdValid is high. This matches the fixed one-cycle read latency.

// File: rtl/snoop_ctrl_pkg.sv
package snoop_ctrl_pkg;
  localparam int REGION_W = 4;
  localparam int OFFS_W   = 12;
  localparam int ADDR_W   = REGION_W + OFFS_W;
  localparam logic [OFFS_W-1:0] STATUS_OFFS   = 12'h00C;
  localparam logic [OFFS_W-1:0] PORT_CTL_OFFS = 12'h000;
  localparam int SNOOP_BIT = 0;
  localparam int MSG_BIT   = 1;

  typedef logic [1:0] enPair_t;

  typedef struct packed {
    logic                wrHit;
    logic [REGION_W-1:0] wrPort;
    enPair_t             wrVal;
  } wrStrobe_t;
endpackage

// File: rtl/snoop_ctrl_decode.sv
module snoop_ctrl_decode
  import snoop_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_PORTS-1:0] snoopEn,
  input  logic [NUM_PORTS-1:0] msgEn,
  input  logic                 busy,
  output wrStrobe_t            strobe,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busRdValid
);
  logic [REGION_W-1:0] region;
  logic [OFFS_W-1:0]   offs;
  logic [DATA_W-1:0]   rdNext;
  logic                unusedWdata;

  assign region      = busAddr[ADDR_W-1:OFFS_W];
  assign offs        = busAddr[OFFS_W-1:0];
  assign unusedWdata = ^busWdata[DATA_W-1:2];

  always_comb begin
    strobe        = '0;
    strobe.wrVal  = busWdata[1:0];
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (busWrEn && region == REGION_W'(k + 1) && offs == PORT_CTL_OFFS) begin
        strobe.wrHit  = 1'b1;
        strobe.wrPort = REGION_W'(k);
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (region == '0 && offs == STATUS_OFFS) rdNext[0] = busy;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (region == REGION_W'(k + 1) && offs == PORT_CTL_OFFS) begin
        rdNext[SNOOP_BIT] = snoopEn[k];
        rdNext[MSG_BIT]   = msgEn[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdValid <= 1'b0;
      busRdata   <= '0;
    end else begin
      busRdValid <= busRdEn;
      if (busRdEn) busRdata <= rdNext;
    end
  end
endmodule

// File: rtl/snoop_ctrl_ports.sv
module snoop_ctrl_ports
  import snoop_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            strobe,
  input  logic [NUM_PORTS-1:0] portAck,
  output logic [NUM_PORTS-1:0] portReqValid,
  output logic [NUM_PORTS-1:0] portReqSnoop,
  output logic [NUM_PORTS-1:0] portReqMsg,
  output logic [NUM_PORTS-1:0] snoopEn,
  output logic [NUM_PORTS-1:0] msgEn,
  output logic                 busy
);
  logic [NUM_PORTS-1:0] portBusy;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    enPair_t cur, reqVal, heldVal;
    logic    active, heldValid;
    enPair_t curN, reqValN, heldValN, tgt;
    logic    activeN, heldValidN, hasTgt, wrHit, ackHit;

    assign wrHit  = strobe.wrHit && strobe.wrPort == REGION_W'(i);
    assign ackHit = portAck[i] && active;

    always_comb begin
      curN       = cur;
      reqValN    = reqVal;
      heldValN   = heldVal;
      activeN    = active;
      heldValidN = heldValid;
      hasTgt     = 1'b0;
      tgt        = heldVal;
      if (ackHit) begin
        curN       = reqVal;
        heldValidN = 1'b0;
        if (wrHit) begin
          hasTgt = 1'b1;
          tgt    = strobe.wrVal;
        end else begin
          hasTgt = heldValid;
          tgt    = heldVal;
        end
        if (hasTgt && tgt != reqVal) begin
          activeN = 1'b1;
          reqValN = tgt;
        end else begin
          activeN = 1'b0;
        end
      end else if (active) begin
        if (wrHit) begin
          heldValN   = strobe.wrVal;
          heldValidN = strobe.wrVal != reqVal;
        end
      end else if (wrHit && strobe.wrVal != cur) begin
        activeN = 1'b1;
        reqValN = strobe.wrVal;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cur       <= '0;
        reqVal    <= '0;
        heldVal   <= '0;
        active    <= 1'b0;
        heldValid <= 1'b0;
      end else begin
        cur       <= curN;
        reqVal    <= reqValN;
        heldVal   <= heldValN;
        active    <= activeN;
        heldValid <= heldValidN;
      end
    end

    assign portReqValid[i] = active;
    assign portReqSnoop[i] = reqVal[SNOOP_BIT];
    assign portReqMsg[i]   = reqVal[MSG_BIT];
    assign snoopEn[i]      = cur[SNOOP_BIT];
    assign msgEn[i]        = cur[MSG_BIT];
    assign portBusy[i]     = active | heldValid;
  end

  assign busy = |portBusy;
endmodule

// File: rtl/snoop_port_ctrl.sv
module snoop_port_ctrl
  import snoop_ctrl_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [15:0]          busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busRdValid,
  input  logic [NUM_PORTS-1:0] portAck,
  output logic [NUM_PORTS-1:0] portReqValid,
  output logic [NUM_PORTS-1:0] portReqSnoop,
  output logic [NUM_PORTS-1:0] portReqMsg,
  output logic [NUM_PORTS-1:0] snoopEn,
  output logic [NUM_PORTS-1:0] msgEn,
  output logic                 changePending
);
  wrStrobe_t strobe;

  snoop_ctrl_decode #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_decode (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .snoopEn(snoopEn), .msgEn(msgEn),
    .busy(changePending), .strobe(strobe), .busRdata(busRdata),
    .busRdValid(busRdValid)
  );

  snoop_ctrl_ports #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk(clk), .rstN(rstN), .strobe(strobe), .portAck(portAck),
    .portReqValid(portReqValid), .portReqSnoop(portReqSnoop),
    .portReqMsg(portReqMsg), .snoopEn(snoopEn), .msgEn(msgEn),
    .busy(changePending)
  );
endmodule

// File: rtl/snoop_port_ctrl_chk.sv
module snoop_port_ctrl_chk #(
  parameter int NUM_PORTS = 5,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busRdEn,
  input logic [15:0]          busAddr,
  input logic [DATA_W-1:0]    busRdata,
  input logic                 busRdValid,
  input logic [NUM_PORTS-1:0] portAck,
  input logic [NUM_PORTS-1:0] portReqValid,
  input logic [NUM_PORTS-1:0] portReqSnoop,
  input logic [NUM_PORTS-1:0] portReqMsg,
  input logic [NUM_PORTS-1:0] snoopEn,
  input logic [NUM_PORTS-1:0] msgEn,
  input logic                 changePending
);
  // R7
  pending_covers_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|portReqValid) |-> changePending);

  // R2
  status_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 16'h000C) |=> (busRdValid && busRdata[0] == $past(changePending)));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (portReqValid[i] && !portAck[i]) |=>
        (portReqValid[i] && $stable(portReqSnoop[i]) && $stable(portReqMsg[i])));

    // R5
    ack_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
      (portReqValid[i] && portAck[i]) |=>
        (snoopEn[i] == $past(portReqSnoop[i]) && msgEn[i] == $past(portReqMsg[i])));

    // R10
    en_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(portReqValid[i] && portAck[i]) |=> ($stable(snoopEn[i]) && $stable(msgEn[i])));
  end
endmodule

bind snoop_port_ctrl snoop_port_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busRdEn(busRdEn), .busAddr(busAddr),
  .busRdata(busRdata), .busRdValid(busRdValid), .portAck(portAck),
  .portReqValid(portReqValid), .portReqSnoop(portReqSnoop),
  .portReqMsg(portReqMsg), .snoopEn(snoopEn), .msgEn(msgEn),
  .changePending(changePending)
);

// File: tb/sim_snoop_port_ctrl.sv
module sim_snoop_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic busRdValid;
  logic [NP-1:0] portAck = '0;
  logic [NP-1:0] portReqValid, portReqSnoop, portReqMsg, snoopEn, msgEn;
  logic changePending;

  int nChecks = 0;
  int nFails = 0;
  logic [DW-1:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_port_ctrl #(.NUM_PORTS(NP), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRdValid(busRdValid), .portAck(portAck), .portReqValid(portReqValid),
    .portReqSnoop(portReqSnoop), .portReqMsg(portReqMsg), .snoopEn(snoopEn),
    .msgEn(msgEn), .changePending(changePending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [DW-1:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [DW-1:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk); busRdEn = 1'b1; busAddr = a;
    @(negedge clk); busRdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack(input int p);
    @(negedge clk); portAck[p] = 1'b1;
    @(negedge clk); portAck[p] = 1'b0;
  endtask

  // scoreboard monitor for read responses
  always @(negedge clk) begin
    if (busRdValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R2 unexpected read data actual=%0h expected=none", busRdata);
      end else begin
        chk(tagQ.pop_front(), busRdata, expQ.pop_front());
      end
    end
  end

  function automatic logic [15:0] portAddr(input int p);
    return 16'((p + 1) * 16'h1000);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enables", {snoopEn, msgEn}, '0);
    chk("R1 requests", portReqValid, '0);
    chk("R1 pending", changePending, 0);
    rd(16'h000C, 0, "R1 R2 status after reset");

    // R3 enable port 0
    wr(portAddr(0), 32'h3);
    chk("R3 req raised", portReqValid, 5'b00001);
    chk("R3 req value", {portReqMsg[0], portReqSnoop[0]}, 2'b11);
    chk("R3 enables unchanged", snoopEn[0], 0);
    chk("R3 pending", changePending, 1);
    rd(16'h000C, 1, "R2 R7 status busy");
    rd(portAddr(0), 0, "R2 port read before ack");
    ack(0);
    // R5
    chk("R5 snoop applied", snoopEn[0], 1);
    chk("R5 msg applied", msgEn[0], 1);
    chk("R5 req dropped", portReqValid[0], 0);
    chk("R7 pending cleared", changePending, 0);
    rd(portAddr(0), 3, "R2 port read after ack");

    // R6 same value
    wr(portAddr(0), 32'h3);
    chk("R6 no request", portReqValid, '0);
    chk("R6 not pending", changePending, 0);

    // R7 two ports
    wr(portAddr(1), 32'h1);
    wr(portAddr(2), 32'h2);
    chk("R3 two requests", portReqValid, 5'b00110);
    ack(1);
    chk("R7 still pending", changePending, 1);
    chk("R5 port1 snoop", {msgEn[1], snoopEn[1]}, 2'b01);
    ack(2);
    chk("R7 cleared after last", changePending, 0);
    chk("R5 port2 msg only", {msgEn[2], snoopEn[2]}, 2'b10);

    // R8 queued change on port 0
    wr(portAddr(0), 32'h0);
    wr(portAddr(0), 32'h1);
    chk("R4 in-flight value kept", {portReqMsg[0], portReqSnoop[0]}, 2'b00);
    ack(0);
    chk("R8 first applied", {msgEn[0], snoopEn[0]}, 2'b00);
    chk("R8 req kept", portReqValid[0], 1);
    chk("R8 queued value sent", {portReqMsg[0], portReqSnoop[0]}, 2'b01);
    chk("R8 pending", changePending, 1);
    ack(0);
    chk("R8 second applied", {msgEn[0], snoopEn[0]}, 2'b01);
    chk("R8 done", changePending, 0);

    // R9 cancel queued
    wr(portAddr(3), 32'h3);
    wr(portAddr(3), 32'h1);
    wr(portAddr(3), 32'h3);
    ack(3);
    chk("R9 applied", {msgEn[3], snoopEn[3]}, 2'b11);
    chk("R9 no follow-up req", portReqValid[3], 0);
    chk("R9 pending clear", changePending, 0);

    // R10 ignored writes and stray ack
    wr(16'h7000, 32'h3);
    wr(16'h000C, 32'h3);
    wr(16'h1004, 32'h3);
    chk("R10 no request", portReqValid, '0);
    chk("R10 not pending", changePending, 0);
    ack(4);
    chk("R10 stray ack", {msgEn[4], snoopEn[4]}, 2'b00);
    rd(portAddr(4), 0, "R10 port4 untouched");
    rd(16'h7000, 0, "R2 unmapped reads 0");
    rd(portAddr(0), 1, "R10 port0 unchanged");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R2 missing read responses actual=%0d expected=0", expQ.size());
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule